// File: doc/BRIEF.md
# Sixteen-Bit Period Timer with Compare Reset

The block is a 16-bit up-counter that software reaches through four byte-wide registers: the low count byte, the high count byte, a control register and an interrupt register. It counts either every system clock cycle or the rising edges of an external clock. The external clock is first brought into the system clock domain by a two-stage synchronizer. A prescaler of 1, 2, 4 or 8 sits between the selected source and the counter. When the counter wraps from FFFFh to 0000h it latches an overflow flag. An interrupt request is raised while that flag and its enable bit are both set.

A compare unit elsewhere in the chip can drive a single-cycle special-event trigger. The trigger clears the count, so the compare value becomes the timer period. If an A/D-enable input is high, the trigger also produces a one-cycle A/D start pulse. A software write to a count byte in the same cycle as a trigger overrides the trigger's clear.

Two state machines organise the block. The edge detector has states EDGE_LOW and EDGE_HIGH. It moves from EDGE_LOW to EDGE_HIGH when the synchronized clock reads 1, and that transition is the counting edge. It moves from EDGE_HIGH back to EDGE_LOW when the synchronized clock reads 0. Each cycle the count register takes one operation, chosen in strict priority order: CNT_LOAD (register write), then CNT_CLEAR (trigger), then CNT_STEP (prescaler output), otherwise CNT_HOLD.

Top module: `period_timer16`

## Requirements
- R1: After power-on reset, the registers at addresses 0, 1, 2 and 3 all read 00h, and `irq` and `adc_start` are 0.
- R2: With clock source bit1=0, prescale 00 and run bit0=1, the count rises by one on every clock edge. With bit0=0, the count holds its value.
- R3: Prescale field bits 5:4 set to 00, 01, 10 or 11 produces one increment per 1, 2, 4 or 8 source ticks. A write to either count byte (address 0 or 1) restarts the prescaler from zero.
- R4: A wrap from FFFFh to 0000h sets the flag at address 3 bit 0. `irq` is high exactly when that flag and the enable bit at address 3 bit 1 are both 1.
- R5: A trigger pulse clears the count to 0000h and never sets the overflow flag. If `adc_enable` is high, `adc_start` is high for exactly the cycle after the trigger.
- R6: A count-byte write in the same cycle as a trigger loads the written byte, leaves the other byte unchanged, and discards the clear.
- R7: Writing address 3 with bit 0 = 0 clears the flag. If an overflow occurs in the same cycle as that write, the flag stays set.
- R8: With bit1=1, the count advances on rising edges of `ext_clk_in`, after the two-stage synchronizer, through the same prescaler.
- R9: Control register address 2: bits 7:6 always read 0; bits 5:0 (prescale, oscillator enable bit 3, sync-bypass bit 2, source bit 1, run bit 0) read back as written.
- R10: A non-power-on reset (`rst_n` low) clears the control and interrupt registers. It leaves the count unchanged.
- R11: When bit1=1 and bit2=1 are both set, the count is in the unsupported unsynchronized setting and a trigger does not clear it. With bit1=0, the trigger clears the count whatever the value of bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears all state including the count |
| rst_n | input | 1 | Other reset, active low, count preserved |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low count, 1 high count, 2 control, 3 interrupt |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data, combinational |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| evt_trig | input | 1 | Special-event trigger pulse from compare unit |
| adc_enable | input | 1 | A/D converter enabled |
| adc_start | output | 1 | One-cycle A/D start pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `evt_trig` and `wr_en` are synchronous to `clk` and last one cycle per event. They also assume that `ext_clk_in` stays high and low for longer than the synchronizer depth plus one cycle, so that no edge is lost. The stimulus drives every input on the falling clock edge. It pulses triggers and writes for exactly one cycle and holds each external clock phase for four cycles. Reset-related properties are disabled while either reset is low, because the count survives one reset but not the other.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int BYTE_W = 8;
    localparam int PS_W   = 2;

    typedef enum logic [1:0] {
        ADDR_CNT_LO = 2'd0,
        ADDR_CNT_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_IRQ    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            osc_en;
        logic            sync_bypass;
        logic            ext_src;
        logic            run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        EDGE_LOW,
        EDGE_HIGH
    } edge_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_LOAD,
        CNT_CLEAR,
        CNT_STEP
    } cnt_op_e;
endpackage

// File: rtl/ext_edge_sync.sv
module ext_edge_sync
    import ptmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    edge_state_e            state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        edge_o  = 1'b0;
        unique case (state_q)
            EDGE_LOW: begin
                if (synced) begin
                    state_d = EDGE_HIGH;
                    edge_o  = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!synced) state_d = EDGE_LOW;
            end
        endcase
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic [PS_W-1:0] sel,
    output logic            inc
);
    localparam int CNT_W = (1 << PS_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(sel)) limit[i] = 1'b1;
        end
    end

    assign inc = adv && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv) cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/period_timer16.sv
module period_timer16
    import ptmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ext_clk_in,
    input  logic              evt_trig,
    input  logic              adc_enable,
    output logic              adc_start,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             any_rst_n;
    ctrl_t            ctrl_q;
    logic             flag_q, ie_q, adc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_lo, wr_hi, wr_ctrl, wr_irq, cnt_wr;
    logic             ext_edge, src_tick, adv, inc;
    logic             trig_ok, ovf_evt;
    cnt_op_e          cnt_op;

    assign any_rst_n = por_n & rst_n;

    assign wr_lo   = wr_en && (reg_addr_e'(wr_addr) == ADDR_CNT_LO);
    assign wr_hi   = wr_en && (reg_addr_e'(wr_addr) == ADDR_CNT_HI);
    assign wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
    assign wr_irq  = wr_en && (reg_addr_e'(wr_addr) == ADDR_IRQ);
    assign cnt_wr  = wr_lo || wr_hi;

    ext_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .din    (ext_clk_in),
        .edge_o (ext_edge)
    );

    assign src_tick = ctrl_q.ext_src ? ext_edge : 1'b1;
    assign adv      = ctrl_q.run && src_tick;

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk   (clk),
        .rst_n (any_rst_n),
        .clr   (cnt_wr),
        .adv   (adv),
        .sel   (ctrl_q.ps),
        .inc   (inc)
    );

    // Clear is unsupported for the unsynchronized external setting
    assign trig_ok = !(ctrl_q.ext_src && ctrl_q.sync_bypass);

    always_comb begin
        if (cnt_wr)                   cnt_op = CNT_LOAD;
        else if (evt_trig && trig_ok) cnt_op = CNT_CLEAR;
        else if (inc)                 cnt_op = CNT_STEP;
        else                          cnt_op = CNT_HOLD;
    end

    assign ovf_evt = (cnt_op == CNT_STEP) && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            unique case (cnt_op)
                CNT_LOAD: begin
                    if (wr_lo) cnt_q[BYTE_W-1:0]     <= wr_data;
                    if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_data;
                end
                CNT_CLEAR: cnt_q <= '0;
                CNT_STEP:  cnt_q <= cnt_q + 1'b1;
                CNT_HOLD:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            adc_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (ovf_evt)     flag_q <= 1'b1;
            else if (wr_irq) flag_q <= wr_data[0];
            if (wr_irq) ie_q <= wr_data[1];
            adc_q <= evt_trig && adc_enable;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_CNT_LO: rd_data = cnt_q[BYTE_W-1:0];
            ADDR_CNT_HI: rd_data = cnt_q[CNT_W-1:BYTE_W];
            ADDR_CTRL:   rd_data = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_IRQ:    rd_data = {{(BYTE_W-2){1'b0}}, ie_q, flag_q};
        endcase
    end

    assign adc_start = adc_q;
    assign irq       = flag_q & ie_q;
endmodule

// File: rtl/period_timer16_chk.sv
module period_timer16_chk (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic        evt_trig,
    input logic        adc_enable,
    input logic        adc_start,
    input logic [15:0] cnt,
    input logic        flag,
    input logic        run,
    input logic        ext_src,
    input logic        sync_bypass,
    input logic        ovf_evt
);
    logic cnt_wr_c, irq_wr_c, trig_ok_c;
    assign cnt_wr_c  = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
    assign irq_wr_c  = wr_en && (wr_addr == 2'd3);
    assign trig_ok_c = !(ext_src && sync_bypass);

    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!run && !cnt_wr_c && !evt_trig) |=> $stable(cnt));

    p_step_by_one_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!cnt_wr_c && !evt_trig) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

    p_flag_source_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(flag) |-> ($past(cnt) == 16'hFFFF || $past(irq_wr_c && wr_data[0])));

    p_trig_clears_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (evt_trig && trig_ok_c && !cnt_wr_c) |=> (cnt == 16'h0000));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (evt_trig && trig_ok_c && !flag && !irq_wr_c) |=> !flag);

    p_adc_pulse_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        adc_start |-> $past(evt_trig && adc_enable));

    p_write_wins_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && wr_addr == 2'd0 && evt_trig) |=> (cnt[7:0] == $past(wr_data)));

    p_ovf_beats_clear_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ovf_evt |=> flag);
endmodule

bind period_timer16 period_timer16_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .evt_trig    (evt_trig),
    .adc_enable  (adc_enable),
    .adc_start   (adc_start),
    .cnt         (cnt_q),
    .flag        (flag_q),
    .run         (ctrl_q.run),
    .ext_src     (ctrl_q.ext_src),
    .sync_bypass (ctrl_q.sync_bypass),
    .ovf_evt     (ovf_evt)
);

// File: tb/tb_period_timer16.sv
module tb_period_timer16;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk_in = 1'b0, evt_trig = 1'b0, adc_enable = 1'b0;
    logic       adc_start, irq;

    int n_checks = 0;
    int n_fail   = 0;

    period_timer16 dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk_in(ext_clk_in), .evt_trig(evt_trig),
        .adc_enable(adc_enable), .adc_start(adc_start), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] lo, hi;
        rd(2'd0, lo); rd(2'd1, hi);
        c = {hi, lo};
    endtask

    task automatic set_count(input logic [15:0] v);
        wr(2'd1, v[15:8]);
        wr(2'd0, v[7:0]);
    endtask

    task automatic trig_pulse(input logic adc_en);
        evt_trig = 1'b1; adc_enable = adc_en;
        @(negedge clk);
        evt_trig = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reg after por", d, 0);
        end
        check("R1 irq", irq, 0);
        check("R1 adc_start", adc_start, 0);
    endtask

    task automatic t_run_hold;
        logic [15:0] c;
        wr(2'd2, 8'h00); set_count(16'h0005);
        repeat (5) @(negedge clk);
        rd_cnt(c); check("R2 hold while off", c, 16'h0005);
        wr(2'd2, 8'h01);
        rd_cnt(c); check("R2 no step on enabling edge", c, 16'h0005);
        repeat (7) @(negedge clk);
        rd_cnt(c); check("R2 one step per clock", c, 16'h000C);
        wr(2'd2, 8'h00);
        repeat (4) @(negedge clk);
        rd_cnt(c); check("R2 hold after stop", c, 16'h000D);
    endtask

    task automatic t_prescale;
        logic [15:0] c;
        for (int ps = 0; ps < 4; ps++) begin
            wr(2'd2, 8'((ps << 4) | 1));
            set_count(16'h0000);
            repeat (8 * (1 << ps)) @(negedge clk);
            rd_cnt(c); check($sformatf("R3 divide code %0d", ps), c, 8);
        end
        wr(2'd2, 8'h31); set_count(16'h0000);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h40);
        repeat (7) @(negedge clk);
        rd_cnt(c); check("R3 prescaler restarted by write", c, 16'h0040);
        @(negedge clk);
        rd_cnt(c); check("R3 step after full period", c, 16'h0041);
    endtask

    task automatic t_overflow;
        logic [15:0] c; logic [7:0] d;
        wr(2'd2, 8'h01); wr(2'd3, 8'h00); set_count(16'hFFFD);
        repeat (2) @(negedge clk);
        rd(2'd3, d); check("R4 flag clear before wrap", d[0], 0);
        @(negedge clk);
        rd_cnt(c); check("R4 wrap to zero", c, 0);
        rd(2'd3, d); check("R4 flag set on wrap", d[0], 1);
        check("R4 irq masked", irq, 0);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h03);
        check("R4 irq when enabled", irq, 1);
        wr(2'd3, 8'h02);
        rd(2'd3, d); check("R7 write zero clears flag", d[0], 0);
        check("R4 irq drops with flag", irq, 0);
    endtask

    task automatic t_ovf_wins;
        logic [7:0] d;
        wr(2'd2, 8'h01); set_count(16'hFFFE);
        @(negedge clk);
        wr(2'd3, 8'h02);
        rd(2'd3, d); check("R7 overflow beats clear", d[0], 1);
        wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    endtask

    task automatic t_trigger;
        logic [15:0] c; logic [7:0] d;
        wr(2'd2, 8'h01); set_count(16'h1234);
        trig_pulse(1'b1);
        rd_cnt(c); check("R5 trigger clears count", c, 0);
        check("R5 adc pulse", adc_start, 1);
        @(negedge clk);
        check("R5 adc pulse one cycle", adc_start, 0);
        rd_cnt(c); check("R5 count resumes", c, 1);
        set_count(16'hFFFE);
        @(negedge clk);
        trig_pulse(1'b0);
        rd_cnt(c); check("R5 clear at FFFF", c, 0);
        rd(2'd3, d); check("R5 trigger sets no flag", d[0], 0);
        check("R5 no adc pulse when disabled", adc_start, 0);
    endtask

    task automatic t_write_vs_trig;
        logic [15:0] c;
        wr(2'd2, 8'h00); set_count(16'h5A00);
        evt_trig = 1'b1; adc_enable = 1'b0;
        wr(2'd0, 8'h77);
        evt_trig = 1'b0;
        rd_cnt(c); check("R6 write wins over trigger", c, 16'h5A77);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; repeat (4) @(negedge clk);
            ext_clk_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_external;
        logic [15:0] c;
        wr(2'd2, 8'h03); set_count(16'h0000);
        ext_pulses(6);
        rd_cnt(c); check("R8 external edges counted", c, 6);
        wr(2'd2, 8'h13); set_count(16'h0000);
        ext_pulses(6);
        rd_cnt(c); check("R8 external with divide by 2", c, 3);
    endtask

    task automatic t_bypass;
        logic [15:0] c;
        wr(2'd2, 8'h07); set_count(16'h0300);
        trig_pulse(1'b0);
        rd_cnt(c); check("R11 trigger ignored unsynchronized", c, 16'h0300);
        wr(2'd2, 8'h04);
        trig_pulse(1'b0);
        rd_cnt(c); check("R11 trigger clears internal source", c, 0);
    endtask

    task automatic t_ctrl_layout;
        logic [7:0] d;
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check("R9 upper bits read zero", d, 8'h3F);
        wr(2'd2, 8'h2C);
        rd(2'd2, d); check("R9 readback", d, 8'h2C);
    endtask

    task automatic t_soft_reset;
        logic [15:0] c; logic [7:0] d;
        wr(2'd2, 8'h00); set_count(16'hBEEF); wr(2'd3, 8'h03);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, d); check("R10 control cleared", d, 0);
        rd(2'd3, d); check("R10 interrupt reg cleared", d, 0);
        check("R10 irq low", irq, 0);
        rd_cnt(c); check("R10 count kept", c, 16'hBEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_hold();
        t_prescale();
        t_overflow();
        t_ovf_wins();
        t_trigger();
        t_write_vs_trig();
        t_external();
        t_bypass();
        t_ctrl_layout();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule